// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs the external side of a single bus transfer on behalf of a core. The core offers a request made of an address, a direction flag and write data. When the sequencer is idle it accepts the request and steps the external bus through four phases. It shows each phase on a two-bit status pair made of a start bit and a transfer bit. While the cycle is in progress it holds the address, direction and write data steady on the bus.

The length of each cycle is set by two things: an active-low acknowledge from the addressed device, and a minimum wait-state count held in a small control register. The wait phase ends only when both are satisfied, so the longer of the two governs. For reads, the sequencer captures the bus data when it leaves the wait phase. In the following cycle it pulses a done flag back to the core.

A built-in decoder turns the status pair into an address strobe and a data strobe. A parameter can remove this decoder. In that case the strobe outputs stay inactive, and external logic decodes the status pair itself.

Top module: `extbus_sequencer`

## Requirements
- R1: While reset is asserted and right after it is released, the status pair {bus_bs, bus_ts} reads 2'b11 (idle), req_ready is 1, rsp_done is 0, and both strobes (bus_as_n, bus_ds_n) are high.
- R2: The status pair encodes 11 = idle, 01 = start, 00 = wait, 10 = end. An accepted request produces exactly one start cycle, then one or more wait cycles, then exactly one end cycle, then idle.
- R3: The number of wait-phase (00) cycles equals 1 + max(N, K). N is the programmed minimum wait count. K is the number of consecutive wait cycles at whose falling clock edge acknowledge (bus_ack_n, active low) was sampled high. The end phase follows one clock after acknowledge is first sampled low while the minimum count has run out.
- R4: With bus_ack_n held low and a minimum count of 0, a transfer spends exactly one cycle in the wait phase (zero wait states).
- R5: bus_ack_n is ignored outside the wait phase. An acknowledge held low during idle or start neither shortens the cycle nor starts one.
- R6: The minimum count is a 4-bit field written through cfg_we/cfg_wdata. It is loaded into the cycle's counter at the cycle-start edge. A write made during a cycle changes only later cycles.
- R7: For a read (req_we = 0), rsp_rdata takes the value bus_rdata had on the clock edge that enters the end phase. Later changes to bus_rdata do not affect it. A write transfer leaves rsp_rdata unchanged.
- R8: rsp_done is high for exactly one cycle per transfer, and that cycle is the end phase.
- R9: req_ready is high only in idle. At least one idle cycle separates an end phase from the next start, even when req_valid stays high. bus_addr, bus_we and bus_wdata stay stable from the start phase through the end phase.
- R10: bus_as_n is low exactly in the start phase, and bus_ds_n is low exactly in the end phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; acknowledge is sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Core offers a transfer |
| req_ready | output | 1 | Sequencer is idle and takes the request this edge |
| req_addr | input | ADDR_W | Transfer address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Data captured by the last read |
| cfg_we | input | 1 | Write strobe for the minimum wait count |
| cfg_wdata | input | WS_W | New minimum wait count |
| bus_addr | output | ADDR_W | Address held on the external bus |
| bus_we | output | 1 | Direction held on the external bus |
| bus_wdata | output | DATA_W | Write data held on the external bus |
| bus_rdata | input | DATA_W | Read data from the external bus |
| bus_ack_n | input | 1 | Active-low transfer acknowledge |
| bus_bs | output | 1 | Status bit: start |
| bus_ts | output | 1 | Status bit: transfer |
| bus_as_n | output | 1 | Decoded active-low address strobe |
| bus_ds_n | output | 1 | Decoded active-low data strobe |

## Verification
The hardest situation to reach is one where the acknowledge and the minimum count disagree about when the wait phase should end. The bench drives the acknowledge cycle by cycle from the moment it sees the wait code. It sweeps every minimum count from 0 to 15 against acknowledge delays below, equal to and above that count, so each of the two limits is the binding one in some transfer. Further stimulus covers a count rewritten during a wait phase, an acknowledge held asserted before the cycle starts, and a request held high through the end phase.

// File: rtl/extbus_pkg.sv
`timescale 1ns/1ps
package extbus_pkg;

  // Phase values double as the {start, transfer} status pair on the bus.
  typedef enum logic [1:0] {
    PH_WAIT  = 2'b00,
    PH_START = 2'b01,
    PH_END   = 2'b10,
    PH_IDLE  = 2'b11
  } bus_phase_t;

endpackage

// File: rtl/extbus_waitctl.sv
`timescale 1ns/1ps
module extbus_waitctl #(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [WS_W-1:0] cfg_wdata,
  input  logic            cnt_load,
  input  logic            in_wait,
  input  logic            ack_n,
  output logic            wait_ok
);

  logic [WS_W-1:0] min_q;
  logic [WS_W-1:0] min_d;
  logic [WS_W-1:0] cnt_q;
  logic [WS_W-1:0] cnt_d;
  logic            ack_q;
  logic            cnt_zero;

  // Minimum wait count register.
  always_comb begin
    min_d = min_q;
    if (cfg_we) min_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) min_q <= '0;
    else        min_q <= min_d;
  end

  // Down-counter: loaded at cycle start, decremented while waiting.
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_load)                   cnt_d = min_q;
    else if (in_wait && !cnt_zero)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Acknowledge is taken on the falling edge, stored active high.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ~ack_n;
  end

  assign wait_ok = in_wait && cnt_zero && ack_q;

endmodule

// File: rtl/extbus_fsm.sv
`timescale 1ns/1ps
module extbus_fsm
  import extbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       wait_ok,
  output bus_phase_t phase,
  output logic       accept,
  output logic       enter_end,
  output logic       done
);

  bus_phase_t phase_q;
  bus_phase_t phase_d;
  logic       done_q;

  assign accept    = (phase_q == PH_IDLE) && req_valid;
  assign enter_end = (phase_q == PH_WAIT) && wait_ok;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (accept)    phase_d = PH_START;
      PH_START:                phase_d = PH_WAIT;
      PH_WAIT:  if (enter_end) phase_d = PH_END;
      PH_END:                  phase_d = PH_IDLE;
      default:                 phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= enter_end;
    end
  end

  assign phase = phase_q;
  assign done  = done_q;

endmodule

// File: rtl/extbus_datapath.sv
`timescale 1ns/1ps
module extbus_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              enter_end,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rd_cap_en;

  // Request fields: clock-enabled by acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      we_q    <= req_we;
      wdata_q <= req_wdata;
    end
  end

  // Read capture on the edge that leaves the wait phase.
  assign rd_cap_en = enter_end && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (rd_cap_en) rdata_q <= bus_rdata;
  end

  assign bus_addr  = addr_q;
  assign bus_we    = we_q;
  assign bus_wdata = wdata_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/extbus_strobe_dec.sv
`timescale 1ns/1ps
module extbus_strobe_dec
  import extbus_pkg::*;
#(
  parameter bit USE_DECODER = 1'b1
) (
  input  bus_phase_t phase,
  output logic       as_n,
  output logic       ds_n
);

  generate
    if (USE_DECODER) begin : g_dec
      assign as_n = (phase != PH_START);
      assign ds_n = (phase != PH_END);
    end else begin : g_nodec
      logic unused_phase;
      assign unused_phase = ^phase;
      assign as_n = 1'b1;
      assign ds_n = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/extbus_sequencer.sv
`timescale 1ns/1ps
module extbus_sequencer
  import extbus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int WS_W        = 4,
  parameter bit USE_DECODER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cfg_we,
  input  logic [WS_W-1:0]   cfg_wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack_n,
  output logic              bus_bs,
  output logic              bus_ts,
  output logic              bus_as_n,
  output logic              bus_ds_n
);

  bus_phase_t phase;
  logic       accept;
  logic       enter_end;
  logic       wait_ok;
  logic       in_wait;

  assign in_wait = (phase == PH_WAIT);

  extbus_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .wait_ok   (wait_ok),
    .phase     (phase),
    .accept    (accept),
    .enter_end (enter_end),
    .done      (rsp_done)
  );

  extbus_waitctl #(.WS_W(WS_W)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cnt_load  (accept),
    .in_wait   (in_wait),
    .ack_n     (bus_ack_n),
    .wait_ok   (wait_ok)
  );

  extbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .enter_end (enter_end),
    .req_addr  (req_addr),
    .req_we    (req_we),
    .req_wdata (req_wdata),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .rsp_rdata (rsp_rdata)
  );

  extbus_strobe_dec #(.USE_DECODER(USE_DECODER)) u_dec (
    .phase (phase),
    .as_n  (bus_as_n),
    .ds_n  (bus_ds_n)
  );

  assign req_ready = (phase == PH_IDLE);
  assign bus_bs    = phase[1];
  assign bus_ts    = phase[0];

endmodule

// File: rtl/extbus_sequencer_chk.sv
`timescale 1ns/1ps
module extbus_sequencer_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              bus_ack_n,
  input logic              bus_bs,
  input logic              bus_ts,
  input logic              bus_as_n,
  input logic              bus_ds_n,
  input logic [ADDR_W-1:0] bus_addr
);

  logic [1:0] st;
  assign st = {bus_bs, bus_ts};

  AST_START_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'b01 |=> st == 2'b00); // R2

  AST_IDLE_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'b11 |=> (st == 2'b11 || st == 2'b01)); // R2

  AST_NO_END_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'b00 && bus_ack_n) |=> st == 2'b00); // R3

  AST_END_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'b10 |=> st == 2'b11); // R9

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> st == 2'b11); // R9

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'b00 || st == 2'b10) |-> $stable(bus_addr)); // R9

  AST_DONE_IN_END: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> st == 2'b10); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_as_n == 1'b0 && bus_ds_n == 1'b0)); // R10

endmodule

bind extbus_sequencer extbus_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .bus_ack_n (bus_ack_n),
  .bus_bs    (bus_bs),
  .bus_ts    (bus_ts),
  .bus_as_n  (bus_as_n),
  .bus_ds_n  (bus_ds_n),
  .bus_addr  (bus_addr)
);

// File: tb/extbus_sequencer_test.sv
`timescale 1ns/1ps
module extbus_sequencer_test;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WW = 4;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic          req_we;
  logic [DW-1:0] req_wdata;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic          cfg_we;
  logic [WW-1:0] cfg_wdata;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          bus_ack_n;
  logic          bus_bs;
  logic          bus_ts;
  logic          bus_as_n;
  logic          bus_ds_n;

  int n_chk;
  int n_bad;
  logic [DW-1:0] last_rd;

  extbus_sequencer #(.ADDR_W(AW), .DATA_W(DW), .WS_W(WW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack_n(bus_ack_n),
    .bus_bs(bus_bs), .bus_ts(bus_ts),
    .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic set_min(input int v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = WW'(v);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // One transfer. k = acknowledge delay in wait cycles, nmin = count in force,
  // mid_min >= 0 rewrites the minimum during the first wait cycle,
  // hold = keep req_valid high after acceptance.
  task automatic run_txn(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic [DW-1:0] rd, input int k, input int nmin,
                         input int mid_min, input bit hold);
    int widx;
    int exp_w;
    logic [DW-1:0] exp_rd;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_we    = we;
    req_wdata = wd;
    bus_ack_n = 1'b0;          // asserted before the cycle: must be ignored (R5)
    bus_rdata = ~rd;
    @(posedge clk); #1;
    chk("R2 start code", {bus_bs, bus_ts}, 2'b01);
    chk("R10 address strobe in start", bus_as_n, 1'b0);
    chk("R9 ready low while busy", req_ready, 1'b0);
    if (!hold) req_valid = 1'b0;
    widx = 0;
    @(posedge clk); #1;
    while ({bus_bs, bus_ts} == 2'b00 && widx < 200) begin
      widx++;
      cfg_we    = 1'b0;
      if (mid_min >= 0 && widx == 1) begin
        cfg_we    = 1'b1;
        cfg_wdata = WW'(mid_min);
      end
      bus_ack_n = (widx <= k);
      bus_rdata = rd;
      @(posedge clk); #1;
    end
    cfg_we = 1'b0;
    exp_w  = 1 + ((nmin > k) ? nmin : k);
    exp_rd = we ? last_rd : rd;
    bus_rdata = ~rd;           // change after capture edge (R7)
    chk("R2 end code", {bus_bs, bus_ts}, 2'b10);
    chk("R3 wait cycle count", widx, exp_w);
    chk("R8 done in end phase", rsp_done, 1'b1);
    chk("R10 data strobe in end", bus_ds_n, 1'b0);
    chk("R9 address held", bus_addr, a);
    chk("R9 direction held", bus_we, we);
    if (we) chk("R9 write data held", bus_wdata, wd);
    chk("R7 read capture", rsp_rdata, exp_rd);
    last_rd = exp_rd;
    @(posedge clk); #1;
    chk("R9 idle after end", {bus_bs, bus_ts}, 2'b11);
    chk("R8 done single pulse", rsp_done, 1'b0);
    chk("R7 capture stable", rsp_rdata, exp_rd);
    chk("R10 strobes high in idle", {bus_as_n, bus_ds_n}, 2'b11);
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk     = 0;
    n_bad     = 0;
    last_rd   = '0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_we    = 1'b0;
    req_wdata = '0;
    cfg_we    = 1'b0;
    cfg_wdata = '0;
    bus_rdata = '0;
    bus_ack_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 status in reset", {bus_bs, bus_ts}, 2'b11);
    chk("R1 ready in reset", req_ready, 1'b1);
    chk("R1 done in reset", rsp_done, 1'b0);
    chk("R1 strobes in reset", {bus_as_n, bus_ds_n}, 2'b11);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 idle after release", {bus_bs, bus_ts}, 2'b11);
    chk("R1 rdata after release", rsp_rdata, 16'h0000);
    // R5: acknowledge low while idle starts nothing
    chk("R5 ack alone starts nothing", {bus_bs, bus_ts}, 2'b11);

    // R4: zero wait states
    run_txn(1'b0, 16'h1000, 16'h0, 16'hA5A5, 0, 0, -1, 1'b0);
    run_txn(1'b1, 16'h1002, 16'h3C3C, 16'h0, 0, 0, -1, 1'b0);

    // R3 sweep: every minimum against short, equal and long acknowledge delays
    for (int n = 0; n < 16; n++) begin
      set_min(n);
      for (int j = 0; j < 4; j++) begin
        int kk;
        kk = (j == 0) ? 0 : (j == 1) ? n : (j == 2) ? n + 2 : (n / 2);
        run_txn(((n + j) % 2) == 1, AW'(16'h2000 + n * 8 + j), DW'(16'h5000 + n * 4 + j),
                DW'(16'h9000 + n * 16 + j * 3), kk, n, -1, 1'b0);
      end
    end

    // R6: rewrite during a wait phase applies only to the next cycle
    set_min(1);
    run_txn(1'b0, 16'h3000, 16'h0, 16'h1234, 0, 1, 9, 1'b0);
    run_txn(1'b0, 16'h3004, 16'h0, 16'h4321, 0, 9, -1, 1'b0);
    set_min(0);

    // R9: request held high across the end phase; next start after one idle
    run_txn(1'b0, 16'h4000, 16'h0, 16'hBEEF, 2, 0, -1, 1'b1);
    run_txn(1'b1, 16'h4002, 16'hCAFE, 16'h0, 0, 0, -1, 1'b0);

    finish_run();
  end

endmodule